// File: doc/BRIEF.md
# Two-Stage Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It brings a fast clock down to the comparison rate of the phase detector. Each cycle of `clk` stands for one cycle of the fast input. The first stage is a chain of six toggle stages, and each stage halves the rate of the one before it. A select input picks one of three coarse ratios from that chain: 4, 16 or 32. The second stage counts the coarse ticks with a 6-bit up counter. It compares the incremented count with a programmable modulus using a bitwise XOR equality test. On a match it returns to zero and emits one output pulse. The overall division is therefore the coarse ratio times the modulus. For example, a coarse ratio of 4 with a modulus of 24 divides by 96.

The whole model runs in one clock domain, and the stages advance on clock enables. Ratio and modulus settings are captured only when the counter wraps, so a setting never produces a shortened period. Out-of-range settings are repaired rather than rejected. `out_valid` tells downstream logic that at least one full division period has completed since reset.

Top module: `fbdiv_feedback_divider`

## Requirements
- R1: `sel` is one-hot: bit 0 selects a coarse ratio of 4, bit 1 selects 16 and bit 2 selects 32. The coarse tick comes from the matching tap of the six-stage halving chain.
- R2: Any `sel` code that is not one-hot selects the coarse ratio of 4. This covers 3'b000, 3'b011 and 3'b111.
- R3: With coarse ratio N and modulus M, consecutive rising edges of `div_out` are exactly N*M `clk` cycles apart.
- R4: A `mod` value below 3 acts as 3, and a value above 62 acts as 62.
- R5: `sel` and `mod` are sampled only on the cycle the counter wraps, which is the same edge where `div_out` rises. Any change between wraps, including several changes within one period, has no effect on the period in progress.
- R6: `div_out` is a registered pulse that stays high for exactly N `clk` cycles, where N is the coarse ratio latched at its rising edge.
- R7: While `rst_n` is low (synchronous, active low), `div_out` and `out_valid` are low. The first rise of `div_out` comes N*M cycles after the first clock edge with `rst_n` high, using the settings present during reset. `out_valid` stays low until that rise.
- R8: `out_valid` rises together with the first `div_out` pulse and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; each cycle is one input period |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 3 | One-hot coarse ratio select (4 / 16 / 32) |
| mod | input | 6 | Fine modulus for the second stage, legal 3 to 62 |
| div_out | output | 1 | Divided output pulse sent to the phase detector |
| out_valid | output | 1 | High once the first full division period has completed |

## Verification
The assertions assume that `sel` and `mod` are synchronous to `clk`. They also rely on the clamp: because the active modulus is never below 3, an output pulse always ends at a coarse tick that is not itself a wrap. The stimulus changes settings only at falling clock edges and at arbitrary points inside a period. It deliberately includes out-of-range moduli and non-one-hot selects, so the repair logic, rather than the stimulus, keeps the active configuration legal. One period receives two successive setting changes before its wrap, to show that only the value present at the wrap counts.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // Depth of the halving chain and width of the fine counter
    localparam int unsigned CHAIN_LEN = 6;
    localparam int unsigned CNT_W     = 6;
    localparam int unsigned SEL_W     = 3;

    // Legal fine modulus window
    localparam int unsigned MOD_LO = 3;
    localparam int unsigned MOD_HI = 62;

    // Chain tap indices; tap i divides by 2**(i+1)
    localparam int unsigned TAP_R4  = 1;
    localparam int unsigned TAP_R16 = 3;
    localparam int unsigned TAP_R32 = 4;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] modv;
    } cfg_t;

endpackage

// File: rtl/fbdiv_toggle_chain.sv
module fbdiv_toggle_chain #(
    parameter int unsigned STAGES = fbdiv_pkg::CHAIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [STAGES-1:0] tap
);

    typedef struct packed {
        logic [STAGES-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    // carry[i] is high when every stage below i is set
    logic [STAGES:0] carry;

    assign carry[0] = 1'b1;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            assign carry[i+1] = carry[i] & chain_q.bits[i];
            assign tap[i]     = carry[i+1];
        end
    endgenerate

    always_comb begin
        chain_d = chain_q;
        for (int i = 0; i < int'(STAGES); i++) begin
            chain_d.bits[i] = chain_q.bits[i] ^ carry[i];
        end
        if (clr) begin
            chain_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

endmodule

// File: rtl/fbdiv_cfg_latch.sv
module fbdiv_cfg_latch #(
    parameter int unsigned SEL_W  = fbdiv_pkg::SEL_W,
    parameter int unsigned CNT_W  = fbdiv_pkg::CNT_W,
    parameter int unsigned MOD_LO = fbdiv_pkg::MOD_LO,
    parameter int unsigned MOD_HI = fbdiv_pkg::MOD_HI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [CNT_W-1:0] mod_in,
    output logic [SEL_W-1:0] sel_act,
    output logic [CNT_W-1:0] mod_act
);

    localparam logic [CNT_W-1:0] LO_V      = CNT_W'(MOD_LO);
    localparam logic [CNT_W-1:0] HI_V      = CNT_W'(MOD_HI);
    localparam logic [SEL_W-1:0] SEL_FALLB = SEL_W'(1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] modv;
    } act_t;

    act_t act_d, act_q, fresh;
    logic sel_is_onehot;

    // Repair the raw inputs: clamp the modulus, force a valid select
    always_comb begin
        sel_is_onehot = (sel_in != '0) && ((sel_in & (sel_in - SEL_W'(1))) == '0);
        fresh.sel  = sel_is_onehot ? sel_in : SEL_FALLB;
        if (mod_in < LO_V) begin
            fresh.modv = LO_V;
        end else if (mod_in > HI_V) begin
            fresh.modv = HI_V;
        end else begin
            fresh.modv = mod_in;
        end
    end

    always_comb begin
        act_d = act_q;
        if (load) begin
            act_d = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= fresh;
        end else begin
            act_q <= act_d;
        end
    end

    assign sel_act = act_q.sel;
    assign mod_act = act_q.modv;

    // R4
    mod_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.modv >= LO_V) && (act_q.modv <= HI_V));

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(act_q.sel));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

endmodule

// File: rtl/fbdiv_mod_counter.sv
module fbdiv_mod_counter #(
    parameter int unsigned CNT_W = fbdiv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [CNT_W-1:0] mod_act,
    output logic             wrap,
    output logic             pulse,
    output logic             valid
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             valid;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    always_comb begin
        cnt_inc = ctr_q.cnt + CNT_W'(1);
        // Bitwise XOR equality: all bits agree
        hit     = ~|(cnt_inc ^ mod_act);
        wrap    = ce & hit;

        ctr_d = ctr_q;
        if (ce) begin
            if (hit) begin
                ctr_d.cnt   = '0;
                ctr_d.pulse = 1'b1;
                ctr_d.valid = 1'b1;
            end else begin
                ctr_d.cnt   = cnt_inc;
                ctr_d.pulse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign pulse = ctr_q.pulse;
    assign valid = ctr_q.valid;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.cnt < mod_act);

    // R6
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.pulse && !ce |=> ctr_q.pulse);

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.pulse && ce |=> !ctr_q.pulse);

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.valid |=> ctr_q.valid);

endmodule

// File: rtl/fbdiv_feedback_divider.sv
module fbdiv_feedback_divider #(
    parameter int unsigned STAGES  = fbdiv_pkg::CHAIN_LEN,
    parameter int unsigned CNT_W   = fbdiv_pkg::CNT_W,
    parameter int unsigned SEL_W   = fbdiv_pkg::SEL_W,
    parameter int unsigned MOD_LO  = fbdiv_pkg::MOD_LO,
    parameter int unsigned MOD_HI  = fbdiv_pkg::MOD_HI,
    parameter int unsigned TAP_R4  = fbdiv_pkg::TAP_R4,
    parameter int unsigned TAP_R16 = fbdiv_pkg::TAP_R16,
    parameter int unsigned TAP_R32 = fbdiv_pkg::TAP_R32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] mod,
    output logic             div_out,
    output logic             out_valid
);

    logic [STAGES-1:0] tap;
    logic [SEL_W-1:0]  sel_act;
    logic [CNT_W-1:0]  mod_act;
    logic [SEL_W-1:0]  tap_pick;
    logic              coarse_ce;
    logic              wrap;

    // Restart the chain at each wrap so a new ratio starts a full tick
    fbdiv_toggle_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wrap),
        .tap   (tap)
    );

    fbdiv_cfg_latch #(
        .SEL_W  (SEL_W),
        .CNT_W  (CNT_W),
        .MOD_LO (MOD_LO),
        .MOD_HI (MOD_HI)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wrap),
        .sel_in  (sel),
        .mod_in  (mod),
        .sel_act (sel_act),
        .mod_act (mod_act)
    );

    always_comb begin
        tap_pick  = {tap[TAP_R32], tap[TAP_R16], tap[TAP_R4]};
        coarse_ce = |(sel_act & tap_pick);
    end

    fbdiv_mod_counter #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (coarse_ce),
        .mod_act (mod_act),
        .wrap    (wrap),
        .pulse   (div_out),
        .valid   (out_valid)
    );

    // R7
    first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> div_out);

    // R1
    tick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_act & tap_pick));

endmodule

// File: tb/tb_fbdiv_feedback_divider.sv
module tb_fbdiv_feedback_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        int    period;
        int    width;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_i = 3'b001;
    logic [5:0] mod_i = 6'd24;
    logic       div_out;
    logic       out_valid;

    exp_t  sb_q[$];
    int    errs   = 0;
    int    checks = 0;
    int    cyc    = 0;
    string cur_req = "R3";
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbdiv_feedback_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_i),
        .mod       (mod_i),
        .div_out   (div_out),
        .out_valid (out_valid)
    );

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        else       cyc <= 0;
    end

    function automatic int eff_n(input logic [2:0] s);
        case (s)
            3'b001:  return 4;
            3'b010:  return 16;
            3'b100:  return 32;
            default: return 4;
        endcase
    endfunction

    function automatic int eff_m(input logic [5:0] m);
        if (m < 6'd3)  return 3;
        if (m > 6'd62) return 62;
        return int'(m);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: measures each period and pulse width against the scoreboard
    bit prev_dout   = 1'b0;
    bit seen_rise   = 1'b0;
    bit valid_early = 1'b0;
    int last_rise   = 0;
    int rise_cyc    = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (div_out && !prev_dout) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected pulse", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check((cyc - last_rise) == e.period, e.req, "period",
                          cyc - last_rise, e.period);
                end
                if (!seen_rise) begin
                    // R7: valid low before the first full period
                    check(!valid_early, "R7", "out_valid early", int'(valid_early), 0);
                end
                // R8: valid present with every pulse
                check(out_valid === 1'b1, "R8", "out_valid at pulse", int'(out_valid), 1);
                seen_rise = 1'b1;
                last_rise = cyc;
                rise_cyc  = cyc;
            end else if (!div_out && prev_dout) begin
                if (sb_q.size() != 0 && sb_q[0].width != 0) begin
                    // R6: pulse width equals coarse ratio
                    check((cyc - rise_cyc) == sb_q[0].width, "R6", "pulse width",
                          cyc - rise_cyc, sb_q[0].width);
                end
            end
            if (!seen_rise && out_valid) valid_early = 1'b1;
            prev_dout = div_out;
        end
    end

    // Driver: at each rise, push the expectation for the period it starts
    task automatic step(input int n);
        repeat (n) begin
            exp_t e;
            @(posedge div_out);
            e.period = eff_n(sel_i) * eff_m(mod_i);
            e.width  = eff_n(sel_i);
            e.req    = cur_req;
            sb_q.push_back(e);
        end
    endtask

    task automatic apply(input logic [2:0] s, input logic [5:0] m, input string req);
        @(negedge clk);
        sel_i   = s;
        mod_i   = m;
        cur_req = req;
    endtask

    initial begin
        exp_t first;
        repeat (4) @(negedge clk);
        // R7: reset state
        check(div_out === 1'b0, "R7", "div_out in reset", int'(div_out), 0);
        check(out_valid === 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        first.period = eff_n(sel_i) * eff_m(mod_i);
        first.width  = 0;
        first.req    = "R7";
        sb_q.push_back(first);
        rst_n = 1'b1;

        cur_req = "R3";
        step(3);                         // /4 * 24 = 96
        apply(3'b010, 6'd5, "R1");       // /16 * 5
        step(2);
        apply(3'b100, 6'd3, "R1");       // /32 * 3, minimum modulus
        step(2);
        apply(3'b001, 6'd62, "R3");      // maximum modulus
        step(2);
        apply(3'b001, 6'd0, "R4");       // clamps to 3
        step(2);
        apply(3'b010, 6'd63, "R4");      // clamps to 62
        step(1);
        apply(3'b000, 6'd10, "R2");      // fallback to /4
        step(2);
        apply(3'b111, 6'd7, "R2");
        step(2);
        apply(3'b011, 6'd2, "R2");       // fallback /4, modulus clamps to 3
        step(2);
        // R5: two changes inside one period; only the last is captured
        @(negedge clk);
        mod_i = 6'd50;
        repeat (5) @(negedge clk);
        sel_i   = 3'b100;
        mod_i   = 6'd9;
        cur_req = "R5";
        step(2);
        @(posedge div_out);
        repeat (40) @(negedge clk);
        check(sb_q.size() == 0, "R3", "pending periods", sb_q.size(), 0);
        check(out_valid === 1'b1, "R8", "out_valid held", int'(out_valid), 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule